// File: doc/BRIEF.md
# Five-Stage PRBS Generator with Step Counter

This block is a 5-stage linear feedback shift register that serves two uses. As a pattern source, it sends a pseudo-random bit stream out of its last stage, for example to exercise a serial link. As a counter, it replaces a binary down-counter. The intermediate states do not matter; only the number of enabled steps needed to reach a programmed terminal state does. A flag marks the cycle in which that state is held.

The feedback polarity can be changed at run time. XOR feedback never visits all-zeros and stalls there. XNOR feedback visits all-zeros but stalls in all-ones. The reset seed is always outside the stall state of the selected polarity. The block checks on every enabled step whether the register holds the stall state of the current polarity, for example after the polarity was switched mid-stream. If it does, the step reloads the seed instead of shifting.

Top module: `prbs_lfsr5`

## Requirements
- R1: On a rising edge with `rst_n` low, `state_out` becomes 5'b00001 when `xnor_sel` is 0 and 5'b11110 when `xnor_sel` is 1.
- R2: With `xnor_sel` 0 and `en` high, and the state not 5'b00000, the next state is `{state[3:0], state[4] ^ state[2]}`.
- R3: With `xnor_sel` 1 and `en` high, and the state not 5'b11111, the next state is `{state[3:0], ~(state[4] ^ state[2])}`.
- R4: In XOR mode, starting at the reset seed, 31 enabled steps visit 31 distinct states, never 5'b00000, and return to the seed.
- R5: In XNOR mode, starting at the reset seed, 31 enabled steps visit 31 distinct states, including 5'b00000 but never 5'b11111, and return to the seed.
- R6: If `en` is high and the state is the stall state of the current polarity (5'b00000 for XOR, 5'b11111 for XNOR), the next state is that polarity's reset seed.
- R7: While `en` is low, the state does not change and `term_hit` stays 0.
- R8: `term_hit` is 1 in exactly those cycles where `en` is high and `state_out` equals `term_val`. It follows in the same cycle, with no register delay.
- R9: `prbs_out` always equals bit 4 of `state_out`, so it changes only on enabled edges.
- R10: Over one XOR period, taken cyclically, the longest run of ones on `prbs_out` is 5 and the longest run of zeros is 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Step enable |
| xnor_sel | input | 1 | Feedback polarity: 0 = XOR, 1 = XNOR |
| term_val | input | 5 | Terminal state to match |
| prbs_out | output | 1 | Serial pseudo-random bit (stage 4) |
| state_out | output | 5 | Current register contents |
| term_hit | output | 1 | High while enabled and state equals `term_val` |

## Verification
`state_out` and `prbs_out` take their new value one rising edge after an enabled step or a reset. `term_hit` is combinational, so it reflects the new state and the held inputs in the same cycle. The bench changes inputs on the falling edge. At the next rising edge it pushes the expected state and flag into a scoreboard queue. A monitor pops that entry 2 ns after the edge, so every comparison falls inside the cycle in which the result is due. The direct period, run-length and recovery checks read the ports 3 ns after the same edge.

// File: rtl/prbs_lfsr_pkg.sv
// Package: shared types for the five-stage PRBS generator.
// Assumes: no other package defines these names.
package prbs_lfsr_pkg;

    // Feedback polarity of the shift register
    typedef enum logic {
        FB_XOR  = 1'b0,
        FB_XNOR = 1'b1
    } fb_mode_e;

endpackage

// File: rtl/lfsr_feedback.sv
// Module: lfsr_feedback
// Forms the shifted next value of a Fibonacci LFSR from two tap stages.
// The new bit enters stage 0. XNOR mode inverts the combined tap value.
// Assumes: TAP_HI and TAP_LO are below WIDTH and give a primitive polynomial.
module lfsr_feedback
    import prbs_lfsr_pkg::*;
#(
    parameter int WIDTH  = 5,
    parameter int TAP_HI = 4,
    parameter int TAP_LO = 2
) (
    input  logic [WIDTH-1:0] cur,
    input  fb_mode_e         mode,
    output logic [WIDTH-1:0] shifted
);

    logic tap_mix;
    logic new_bit;

    // Combine the taps and apply the selected polarity
    always_comb begin
        tap_mix = cur[TAP_HI] ^ cur[TAP_LO];
        new_bit = (mode == FB_XNOR) ? ~tap_mix : tap_mix;
    end

    // Shift toward the high stage and insert the new bit at stage 0
    assign shifted = {cur[WIDTH-2:0], new_bit};

endmodule

// File: rtl/lockup_guard.sv
// Module: lockup_guard
// Gives the reset seed for the active polarity and flags the stall state.
// The stall state is all zeros for XOR and all ones for XNOR.
// Assumes: WIDTH is at least 2.
module lockup_guard
    import prbs_lfsr_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] cur,
    input  fb_mode_e         mode,
    output logic             locked,
    output logic [WIDTH-1:0] seed
);

    localparam logic [WIDTH-1:0] ALL_ZERO  = '0;
    localparam logic [WIDTH-1:0] ALL_ONE   = '1;
    localparam logic [WIDTH-1:0] SEED_XOR  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] SEED_XNOR = ~SEED_XOR;

    // Choose the seed and the stall pattern of the active polarity
    always_comb begin
        if (mode == FB_XNOR) begin
            seed   = SEED_XNOR;
            locked = (cur == ALL_ONE);
        end else begin
            seed   = SEED_XOR;
            locked = (cur == ALL_ZERO);
        end
    end

endmodule

// File: rtl/term_detect.sv
// Module: term_detect
// Raises the hit flag while enabled and the state equals the terminal value.
// Assumes: the caller drives a registered state, so the flag never glitches
// across a clock edge.
module term_detect #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] term,
    input  logic             en,
    output logic             hit
);

    // Compare the state with the terminal value, gated by enable
    assign hit = en && (cur == term);

endmodule

// File: rtl/prbs_lfsr5.sv
// Module: prbs_lfsr5 (top)
// Maximal-length LFSR with run-time XOR/XNOR feedback. Stage 4 drives the
// serial output. A terminal-state match makes the block usable as a counter.
// On an enabled step from the stall state, the seed is reloaded.
// Assumes: synchronous active-low reset; the default taps give a 31-state cycle.
module prbs_lfsr5
    import prbs_lfsr_pkg::*;
#(
    parameter int WIDTH  = 5,
    parameter int TAP_HI = 4,
    parameter int TAP_LO = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             xnor_sel,
    input  logic [WIDTH-1:0] term_val,
    output logic             prbs_out,
    output logic [WIDTH-1:0] state_out,
    output logic             term_hit
);

    localparam logic [WIDTH-1:0] STALL_XOR  = '0;
    localparam logic [WIDTH-1:0] STALL_XNOR = '1;
    localparam logic [WIDTH-1:0] SEED_XOR   = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] SEED_XNOR  = ~SEED_XOR;

    fb_mode_e          mode;
    logic [WIDTH-1:0]  state_q;
    logic [WIDTH-1:0]  shifted;
    logic [WIDTH-1:0]  seed;
    logic              locked;

    assign mode = fb_mode_e'(xnor_sel);

    lfsr_feedback #(
        .WIDTH (WIDTH),
        .TAP_HI(TAP_HI),
        .TAP_LO(TAP_LO)
    ) u_feedback (
        .cur    (state_q),
        .mode   (mode),
        .shifted(shifted)
    );

    lockup_guard #(
        .WIDTH(WIDTH)
    ) u_guard (
        .cur   (state_q),
        .mode  (mode),
        .locked(locked),
        .seed  (seed)
    );

    term_detect #(
        .WIDTH(WIDTH)
    ) u_term (
        .cur (state_q),
        .term(term_val),
        .en  (en),
        .hit (term_hit)
    );

    // State register: load the seed on reset, step or recover when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= seed;
        end else if (en) begin
            state_q <= locked ? seed : shifted;
        end
    end

    assign state_out = state_q;
    assign prbs_out  = state_q[WIDTH-1];

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q));

    // R2
    step_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !xnor_sel && state_q != STALL_XOR) |=>
        state_q == {$past(state_q[WIDTH-2:0]),
                    $past(state_q[TAP_HI] ^ state_q[TAP_LO])});

    // R3
    step_xnor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && xnor_sel && state_q != STALL_XNOR) |=>
        state_q == {$past(state_q[WIDTH-2:0]),
                    ~$past(state_q[TAP_HI] ^ state_q[TAP_LO])});

    // R6
    recover_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !xnor_sel && state_q == STALL_XOR) |=> state_q == SEED_XOR);

    // R6
    recover_xnor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && xnor_sel && state_q == STALL_XNOR) |=> state_q == SEED_XNOR);

endmodule

// File: tb/tb_prbs_lfsr5.sv
// Scoreboard bench for prbs_lfsr5: a driver task queues expected results and
// a monitor process compares them 2 ns after each rising edge.
module tb_prbs_lfsr5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       xnor_sel;
    logic [4:0] term_val;
    logic       prbs_out;
    logic [4:0] state_out;
    logic       term_hit;

    always #10 clk = ~clk;

    prbs_lfsr5 dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .xnor_sel (xnor_sel),
        .term_val (term_val),
        .prbs_out (prbs_out),
        .state_out(state_out),
        .term_hit (term_hit)
    );

    typedef struct {
        logic [4:0] st;
        logic       hit;
        string      req;
    } exp_t;

    exp_t       sbq[$];
    logic [4:0] m_state;
    int         checks   = 0;
    int         errors   = 0;
    bit         finished = 0;
    logic [4:0] obs[31];
    bit         pbit[31];

    function automatic logic [4:0] seed_of(bit p);
        return p ? 5'b11110 : 5'b00001;
    endfunction

    function automatic logic [4:0] next_of(logic [4:0] s, bit p);
        logic b;
        if (s == (p ? 5'b11111 : 5'b00000)) return seed_of(p);
        b = s[4] ^ s[2];
        if (p) b = ~b;
        return {s[3:0], b};
    endfunction

    task automatic note(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive inputs at the falling edge; queue the expected post-edge result
    task automatic step(bit r, bit e, bit p, logic [4:0] t, string req);
        @(negedge clk);
        rst_n = r; en = e; xnor_sel = p; term_val = t;
        @(posedge clk);
        if (!r) m_state = seed_of(p);
        else if (e) m_state = next_of(m_state, p);
        sbq.push_back('{m_state, e && (m_state == t), req});
    endtask

    // Monitor: compare queued expectations with the ports
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sbq.size() > 0) begin
                exp_t x;
                x = sbq.pop_front();
                note(state_out === x.st, x.req, "state", state_out, x.st);
                note(prbs_out === x.st[4], "R9", "prbs_out", prbs_out, x.st[4]);
                note(term_hit === x.hit, "R8", "term_hit", term_hit, x.hit);
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; xnor_sel = 1'b0; term_val = '0; m_state = '0;

        // R1: reset seed in both polarities
        step(0, 0, 0, 5'd0, "R1");
        #3 note(state_out == 5'b00001, "R1", "xor seed", state_out, 5'b00001);
        step(0, 0, 1, 5'd0, "R1");
        #3 note(state_out == 5'b11110, "R1", "xnor seed", state_out, 5'b11110);

        // R2 R4 R10: one full XOR period
        step(0, 0, 0, 5'd0, "R1");
        for (int i = 0; i < 31; i++) begin
            step(1, 1, 0, 5'd31, "R2");
            #3;
            obs[i]  = state_out;
            pbit[i] = prbs_out;
        end
        begin
            bit seen[32];
            int distinct = 0;
            int zeros = 0;
            int r1 = 0, r0 = 0, m1 = 0, m0 = 0;
            foreach (seen[k]) seen[k] = 0;
            for (int i = 0; i < 31; i++) begin
                if (!seen[obs[i]]) distinct++;
                seen[obs[i]] = 1;
                if (obs[i] == 5'd0) zeros++;
            end
            note(distinct == 31, "R4", "distinct xor states", distinct, 31);
            note(zeros == 0, "R4", "xor zero visits", zeros, 0);
            note(obs[30] == 5'b00001, "R4", "xor wrap to seed", obs[30], 1);
            for (int i = 0; i < 62; i++) begin
                if (pbit[i % 31]) begin r1++; r0 = 0; end
                else begin r0++; r1 = 0; end
                if (r1 > m1) m1 = r1;
                if (r0 > m0) m0 = r0;
            end
            note(m1 == 5, "R10", "longest ones run", m1, 5);
            note(m0 == 4, "R10", "longest zeros run", m0, 4);
        end

        // R3 R5: one full XNOR period
        step(0, 0, 1, 5'd0, "R1");
        for (int i = 0; i < 31; i++) begin
            step(1, 1, 1, 5'd0, "R3");
            #3 obs[i] = state_out;
        end
        begin
            bit seen[32];
            int distinct = 0;
            int zeros = 0;
            int ones = 0;
            foreach (seen[k]) seen[k] = 0;
            for (int i = 0; i < 31; i++) begin
                if (!seen[obs[i]]) distinct++;
                seen[obs[i]] = 1;
                if (obs[i] == 5'd0) zeros++;
                if (obs[i] == 5'd31) ones++;
            end
            note(distinct == 31, "R5", "distinct xnor states", distinct, 31);
            note(zeros == 1, "R5", "xnor zero visits", zeros, 1);
            note(ones == 0, "R5", "xnor ones visits", ones, 0);
            note(obs[30] == 5'b11110, "R5", "xnor wrap to seed", obs[30], 30);
        end

        // R6: XNOR run to all-zeros, switch to XOR, expect reload
        step(0, 0, 1, 5'd0, "R1");
        for (int i = 0; i < 31 && m_state != 5'd0; i++) step(1, 1, 1, 5'd1, "R3");
        #3 note(state_out == 5'd0, "R6", "reached zeros", state_out, 0);
        step(1, 1, 0, 5'd0, "R6");
        #3 note(state_out == 5'b00001, "R6", "xor recovery", state_out, 1);

        // R6: XOR run to all-ones, switch to XNOR, expect reload
        step(0, 0, 0, 5'd0, "R1");
        for (int i = 0; i < 31 && m_state != 5'd31; i++) step(1, 1, 0, 5'd0, "R2");
        #3 note(state_out == 5'd31, "R6", "reached ones", state_out, 31);
        step(1, 1, 1, 5'd0, "R6");
        #3 note(state_out == 5'b11110, "R6", "xnor recovery", state_out, 30);

        // R7: enable low holds state even when term_val matches
        begin
            logic [4:0] held;
            held = m_state;
            repeat (3) step(1, 0, 1, held, "R7");
            #3 note(state_out == held, "R7", "held state", state_out, held);
            note(term_hit == 1'b0, "R7", "hit while idle", term_hit, 0);
        end

        // R8: counting use, terminal value 9 steps past the XOR seed
        begin
            logic [4:0] tgt;
            int hits = 0;
            int first = -1;
            tgt = 5'b00001;
            repeat (9) tgt = next_of(tgt, 0);
            step(0, 0, 0, tgt, "R1");
            for (int i = 1; i <= 31; i++) begin
                step(1, 1, 0, tgt, "R8");
                #3;
                if (term_hit) begin
                    hits++;
                    if (first < 0) first = i;
                end
            end
            note(first == 9, "R8", "steps to terminal", first, 9);
            note(hits == 1, "R8", "hits per period", hits, 1);
        end

        @(posedge clk);
        #5;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule